// File: doc/BRIEF.md
# Quasi-synchronous clock filter

This block turns a set of free-running candidate clock enables into a set of filtered enables that stay quasi-synchronous. On every clock cycle each of the `N` candidate bits may or may not be high, usually at random. The block passes a candidate through unless passing it would let that clock run too far ahead of another. Between any two ticks of one filtered clock, no other filtered clock ticks more than `D` times.

For every ordered pair of distinct clocks (leader, follower), the block keeps a small counter. The counter holds how many times the leader has ticked since the follower last ticked. When a counter sits at `D` and the follower stays quiet in the current cycle, the leader's candidate is vetoed for that cycle. The counters are brought out so that a surrounding model can observe the drift state.

A veto only ever waits for a follower whose candidate is low, so one suppression never has to be fed back into another. If the leader is saturated against a follower, and that follower is itself saturated against a third clock, then the leader is also saturated against the third clock. A single level of gating therefore gives the exact set of allowed ticks.

Top module: `qs_clock_filter`

## Requirements
- R1: A filtered enable is never high unless its candidate is high in the same cycle.
- R2: The counter for pair (i, j) is set to 0 after a cycle in which filtered clock j ticks. It increments by one after a cycle in which i ticks and j does not. It holds otherwise. It appears on `adv_o` at bits `(i*N+j)*W` upward, where `W = clog2(D+1)`, and diagonal fields (i equal to j) always read 0.
- R3: While reset is asserted, and in the first cycle after it, every counter reads 0.
- R4: No counter ever exceeds `D`. If counter (i, j) equals `D` and filtered clock j does not tick, filtered clock i is low in that cycle.
- R5: A high candidate i is suppressed only when some j has counter (i, j) equal to `D` and j does not tick in that cycle.
- R6: When clocks i and j tick in the same cycle, both counters (i, j) and (j, i) read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cand_i | input | N | Candidate enables, bit k for clock k |
| tick_o | output | N | Filtered enables, combinational from `cand_i` and the counters |
| adv_o | output | N*N*W | Pairwise advance counters, field (i, j) at `(i*N+j)*W` |

## Verification
A directed prologue lets clock 0 run alone until it saturates against both other clocks. It then offers clock 1 alongside clock 0, which shows that a veto depends on the pair: clock 0 stays blocked by the silent clock 2 even though clock 1 ticks. Three random phases follow. With uniform candidates, the counters move in every direction. With one heavily favoured clock, the saturation and veto path is exercised almost every cycle. With sparse candidates, long quiet stretches and simultaneous resets occur. In every cycle the bench checks the bound, the minimality of suppression and the exact counter values against its own model, so over-eager vetoes can be told apart from missing ones.

// File: rtl/qs_clock_filter.sv
module qs_clock_filter #(
  parameter int N = 4,
  parameter int D = 2,
  localparam int W = (D < 2) ? 1 : $clog2(D + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   cand_i,
  output logic [N-1:0]   tick_o,
  output logic [N*N*W-1:0] adv_o
);

  logic [N*N-1:0] sat;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_diag
        assign sat[i*N+j] = 1'b0;
        assign adv_o[(i*N+j)*W +: W] = '0;
      end else begin : g_pair
        logic [W-1:0] cnt;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            cnt <= '0;
          else if (tick_o[j])
            cnt <= '0;
          else if (tick_o[i] && cnt != W'(D))
            cnt <= cnt + 1'b1;
        end
        assign sat[i*N+j] = (cnt == W'(D));
        assign adv_o[(i*N+j)*W +: W] = cnt;
      end
    end
    assign tick_o[i] = cand_i[i] & ~|(sat[i*N +: N] & ~cand_i);
  end

endmodule

// File: rtl/qs_clock_filter_chk.sv
module qs_clock_filter_chk #(
  parameter int N = 4,
  parameter int D = 2,
  parameter int W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     cand_i,
  input logic [N-1:0]     tick_o,
  input logic [N*N*W-1:0] adv_o
);

  p_subset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o & ~cand_i) == '0);

  p_zero_r3: assert property (@(posedge clk) !rst_n |=> adv_o == '0);

  for (genvar i = 0; i < N; i++) begin : g_i
    for (genvar j = 0; j < N; j++) begin : g_j
      if (i != j) begin : g_p
        p_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
          tick_o[j] |=> adv_o[(i*N+j)*W +: W] == '0);
        p_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
          (tick_o[i] && !tick_o[j]) |=>
            adv_o[(i*N+j)*W +: W] == $past(adv_o[(i*N+j)*W +: W]) + W'(1));
        p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
          (!tick_o[i] && !tick_o[j]) |=> $stable(adv_o[(i*N+j)*W +: W]));
        p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
          adv_o[(i*N+j)*W +: W] <= W'(D));
        p_veto_r4: assert property (@(posedge clk) disable iff (!rst_n)
          (adv_o[(i*N+j)*W +: W] == W'(D) && !tick_o[j]) |-> !tick_o[i]);
        p_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
          (tick_o[i] && tick_o[j]) |=>
            (adv_o[(i*N+j)*W +: W] == '0 && adv_o[(j*N+i)*W +: W] == '0));
      end else begin : g_d
        p_diag_r2: assert property (@(posedge clk) disable iff (!rst_n)
          adv_o[(i*N+j)*W +: W] == '0);
      end
    end
    p_lone_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_i[i] && tick_o == '0 && cand_i == (N'(1) << i)) |->
        adv_o[i*N*W +: N*W] != '0);
  end

endmodule

bind qs_clock_filter qs_clock_filter_chk #(.N(N), .D(D), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cand_i(cand_i), .tick_o(tick_o), .adv_o(adv_o)
);

// File: tb/test_qs_clock_filter.sv
module test_qs_clock_filter;
  localparam int N = 3;
  localparam int D = 2;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] cand = '0;
  logic [N-1:0] tick;
  logic [N*N*W-1:0] adv;

  int checks = 0;
  int errors = 0;
  int madv [N][N];

  always #5 clk = ~clk;

  qs_clock_filter #(.N(N), .D(D)) i_qs_clock_filter (
    .clk(clk), .rst_n(rst_n), .cand_i(cand), .tick_o(tick), .adv_o(adv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int fld(input int i, input int j);
    return int'(adv[(i*N+j)*W +: W]);
  endfunction

  task automatic cycle(input logic [N-1:0] c, input bit has_exp, input logic [N-1:0] exp);
    bit bad;
    @(negedge clk);
    cand = c;
    #1;
    bad = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (fld(i, j) != madv[i][j]) bad = 1;
    chk(!bad, "R2 counters", 0, 0);
    chk((tick & ~cand) == '0, "R1 subset", int'(tick), int'(cand));
    bad = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i != j && tick[i] && madv[i][j] == D && !tick[j]) bad = 1;
    chk(!bad, "R4 bound", int'(tick), int'(cand));
    bad = 0;
    for (int i = 0; i < N; i++)
      if (cand[i] && !tick[i]) begin
        bit why = 0;
        for (int j = 0; j < N; j++)
          if (i != j && madv[i][j] == D && !tick[j]) why = 1;
        if (!why) bad = 1;
      end
    chk(!bad, "R5 minimal", int'(tick), int'(cand));
    if (has_exp) chk(tick == exp, "R4/R5 directed tick", int'(tick), int'(exp));
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i != j) begin
          if (tick[j]) madv[i][j] = 0;
          else if (tick[i] && madv[i][j] < D) madv[i][j]++;
        end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) madv[i][j] = 0;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(adv == '0, "R3 reset", int'(adv), 0);
    rst_n = 1'b1;
    cycle(3'b000, 1, 3'b000);
    cycle(3'b001, 1, 3'b001);
    cycle(3'b001, 1, 3'b001);
    cycle(3'b001, 1, 3'b000);
    cycle(3'b011, 1, 3'b010);
    cycle(3'b111, 1, 3'b111);
    @(negedge clk);
    #1;
    chk(adv == '0, "R6 joint reset", int'(adv), 0);
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] c;
      c = N'($urandom);
      cycle(c, 0, '0);
    end
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] c;
      c[0] = ($urandom % 10) < 9;
      c[1] = ($urandom % 10) < 2;
      c[2] = ($urandom % 10) < 3;
      cycle(c, 0, '0);
    end
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] c;
      for (int b = 0; b < N; b++) c[b] = ($urandom % 8) == 0;
      cycle(c, 0, '0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule